// File: doc/BRIEF.md
# Serial Line Code Encoder and Decoder

This block converts a stream of NRZ data bits into one of seven line codes for transmission and recovers NRZ bits from a received coded line. Both directions run from one clock that is also the receive oversampling clock. One cell lasts `OSR` clock cycles, with `OSR` defaulting to 16.

The transmit side accepts one data bit each time the bit enable is high. It sets the cell's first-half level on that same clock edge. For the biphase codes it applies the mid-cell level exactly `OSR/2` cycles later, using its own half-cell counter.

The receive side brings the line into the clock domain and detects level changes. It runs a phase counter that the first detected edge after reset aligns, which also marks the counter as locked. After that, only edges near a cell boundary realign it. The receive side samples the line at one quarter and three quarters of each cell and emits one decoded bit per cell with a single-cycle valid strobe. A 3-bit mode input selects the code for both directions.

Top module: `line_codec`

## Requirements
- R1: Mode 0 (plain NRZ) drives the line to the data bit for the whole cell. Mode 7 behaves exactly like mode 0.
- R2: Mode 1 inverts the line level at the start of a cell carrying 1 and keeps it for 0. Mode 2 inverts for 0 and keeps it for 1. Neither mode changes the line at mid-cell.
- R3: Mode 3 inverts the line at every cell start and inverts it again at mid-cell when the bit is 1.
- R4: Mode 4 inverts the line at every cell start and inverts it again at mid-cell when the bit is 0.
- R5: Mode 5 drives the bit level in the first half of the cell and its complement in the second half.
- R6: Mode 6 inverts the line at every mid-cell. It also inverts the line at the cell start when the bit is 0, and not when the bit is 1.
- R7: The line is 0 after reset. The cell-start level appears on the clock edge that samples `tx_en` high. A mid-cell change appears exactly `OSR/2` clock edges later. The line does not move at any other time.
- R8: No `rx_valid` pulse occurs before the first received line edge after reset. After that, `rx_valid` pulses high for exactly one cycle once per cell, which is every `OSR` cycles for a steady cell length.
- R9: With the line looped back, every mode recovers the transmitted bits in order. The prior-cell level used by modes 1, 2 and 6 starts at 0. The first bit sent must produce a cell-start edge: 0 for modes 2 and 6, and 1 for every other mode.
- R10: An edge arriving in the outer quarter of the cell, or the first edge after reset, restarts the receive phase. With edges in every cell (modes 3 and 4), the bits are still recovered when cell lengths alternate between `OSR-1` and `OSR+1` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the receive oversampling clock (`OSR` cycles per cell) |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Line code select, 0 to 7 |
| tx_bit | input | 1 | NRZ data bit to send |
| tx_en | input | 1 | One-cycle strobe that starts a transmit cell with `tx_bit` |
| tx_line | output | 1 | Encoded line level |
| rx_line | input | 1 | Received encoded line level |
| rx_bit | output | 1 | Recovered NRZ bit |
| rx_valid | output | 1 | One-cycle strobe marking `rx_bit` as valid |

## Verification
The hardest case to reach from the ports is a cell boundary edge that arrives before or after the receive counter's own notion of the boundary. In that case the phase must be pulled back without inventing or dropping a bit. The bench creates this by looping the encoder into the decoder in both transition-every-cell biphase modes while alternating the spacing of `tx_en` between `OSR-1` and `OSR+1` cycles. Every cell boundary is then displaced by one cycle in alternating directions, and the decoded stream must still match. Every mode also sends a data pattern that walks all sixteen 4-bit sequences. Mid-cell timing is checked on the cycles just before and just after the half-cell point.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;

    typedef enum logic [2:0] {
        LC_NRZ    = 3'd0,
        LC_NRZI_M = 3'd1,
        LC_NRZI_S = 3'd2,
        LC_FM1    = 3'd3,
        LC_FM0    = 3'd4,
        LC_MAN    = 3'd5,
        LC_DMAN   = 3'd6,
        LC_RSVD   = 3'd7
    } lc_mode_e;

    typedef struct packed {
        logic h1;   // level sampled in the first half of the cell
        logic h2;   // level sampled in the second half of the cell
    } lc_halves_t;

    // Fold the reserved code onto plain NRZ.
    function automatic lc_mode_e lc_norm(input logic [2:0] m);
        if (m == 3'd7) return LC_NRZ;
        return lc_mode_e'(m);
    endfunction

    // Line level taken at the start of a cell.
    function automatic logic lc_start_level(input lc_mode_e m, input logic b, input logic cur);
        case (m)
            LC_NRZI_M:     return cur ^ b;
            LC_NRZI_S:     return cur ^ ~b;
            LC_FM1,
            LC_FM0:        return ~cur;
            LC_MAN:        return b;
            LC_DMAN:       return b ? cur : ~cur;
            default:       return b;
        endcase
    endfunction

    // Line level taken at mid-cell, given the first-half level.
    function automatic logic lc_mid_level(input lc_mode_e m, input logic b, input logic cur);
        case (m)
            LC_FM1:        return b ? ~cur : cur;
            LC_FM0:        return b ? cur : ~cur;
            LC_MAN,
            LC_DMAN:       return ~cur;
            default:       return cur;
        endcase
    endfunction

    // Recover the NRZ bit from the two half-cell samples and the previous cell's level.
    function automatic logic lc_decide(input lc_mode_e m, input lc_halves_t s, input logic prev);
        case (m)
            LC_NRZI_M:     return s.h2 ^ prev;
            LC_NRZI_S:     return ~(s.h2 ^ prev);
            LC_FM1:        return s.h1 ^ s.h2;
            LC_FM0:        return ~(s.h1 ^ s.h2);
            LC_MAN:        return s.h1;
            LC_DMAN:       return ~(s.h1 ^ prev);
            default:       return s.h2;
        endcase
    endfunction

endpackage

// File: rtl/lc_encoder.sv
module lc_encoder
    import line_codec_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  lc_mode_e mode,
    input  logic     tx_bit,
    input  logic     tx_en,
    output logic     tx_line
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF_C = CW'(OSR / 2);

    logic          line_q;
    logic          bit_q;
    logic          armed_q;
    logic [CW-1:0] hcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b0;
            bit_q   <= 1'b0;
            armed_q <= 1'b0;
            hcnt_q  <= '0;
        end else if (tx_en) begin
            line_q  <= lc_start_level(mode, tx_bit, line_q);
            bit_q   <= tx_bit;
            armed_q <= 1'b1;
            hcnt_q  <= CW'(1);
        end else if (armed_q) begin
            if (hcnt_q == HALF_C) begin
                line_q  <= lc_mid_level(mode, bit_q, line_q);
                armed_q <= 1'b0;
            end else begin
                hcnt_q <= hcnt_q + CW'(1);
            end
        end
    end

    assign tx_line = line_q;

    // R3
    fm_start_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && (mode == LC_FM1 || mode == LC_FM0)) |=> (tx_line != $past(tx_line)));

    // R5
    man_mid_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && armed_q && hcnt_q == HALF_C && mode == LC_MAN) |=> (tx_line == !$past(bit_q)));

    // R7
    line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !armed_q) |=> $stable(tx_line));

endmodule

// File: rtl/lc_rx_sync.sv
module lc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_line,
    output logic lvl,
    output logic edge_seen
);
    logic [STAGES-1:0] chain_q;
    logic              lvl_d_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= rx_line;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], rx_line};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl_d_q <= 1'b0;
        else     lvl_d_q <= chain_q[STAGES-1];
    end

    assign lvl       = chain_q[STAGES-1];
    assign edge_seen = chain_q[STAGES-1] ^ lvl_d_q;

endmodule

// File: rtl/lc_phase_timer.sv
module lc_phase_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    output logic locked,
    output logic tick_h1,
    output logic tick_h2,
    output logic tick_end
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] Q1_C  = CW'(OSR / 4);
    localparam logic [CW-1:0] Q3_C  = CW'(OSR - OSR / 4);
    localparam logic [CW-1:0] END_C = CW'(OSR - 1);

    logic [CW-1:0] cnt_q;
    logic          locked_q;
    logic          in_win;
    logic          resync;

    assign in_win = (cnt_q >= Q3_C) || (cnt_q < Q1_C);
    assign resync = edge_seen && (!locked_q || in_win);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            if (resync) begin
                cnt_q    <= CW'(1);
                locked_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign locked   = locked_q;
    assign tick_h1  = (cnt_q == Q1_C);
    assign tick_h2  = (cnt_q == Q3_C);
    assign tick_end = (cnt_q == END_C);

    // R10
    first_edge_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && !locked) |=> (locked && cnt_q == CW'(1)));

    // R8
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == END_C && !edge_seen) |=> (cnt_q == '0));

endmodule

// File: rtl/lc_cell_decoder.sv
module lc_cell_decoder
    import line_codec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lc_mode_e mode,
    input  logic     lvl,
    input  logic     locked,
    input  logic     tick_h1,
    input  logic     tick_h2,
    input  logic     tick_end,
    output logic     rx_bit,
    output logic     rx_valid
);
    lc_halves_t halves_q;
    logic       prev_q;
    logic       bit_q;
    logic       valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halves_q <= '0;
            prev_q   <= 1'b0;
            bit_q    <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            if (tick_h1) halves_q.h1 <= lvl;
            if (tick_h2) halves_q.h2 <= lvl;
            if (tick_end && locked) begin
                bit_q   <= lc_decide(mode, halves_q, prev_q);
                prev_q  <= halves_q.h2;
                valid_q <= 1'b1;
            end else begin
                valid_q <= 1'b0;
            end
        end
    end

    assign rx_bit   = bit_q;
    assign rx_valid = valid_q;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(locked));

endmodule

// File: rtl/line_codec.sv
module line_codec
    import line_codec_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  logic       tx_bit,
    input  logic       tx_en,
    output logic       tx_line,
    input  logic       rx_line,
    output logic       rx_bit,
    output logic       rx_valid
);
    lc_mode_e mode_n;
    logic     lvl;
    logic     edge_seen;
    logic     locked;
    logic     tick_h1;
    logic     tick_h2;
    logic     tick_end;

    assign mode_n = lc_norm(mode);

    lc_encoder #(.OSR(OSR)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_n),
        .tx_bit  (tx_bit),
        .tx_en   (tx_en),
        .tx_line (tx_line)
    );

    lc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .lvl       (lvl),
        .edge_seen (edge_seen)
    );

    lc_phase_timer #(.OSR(OSR)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .edge_seen (edge_seen),
        .locked    (locked),
        .tick_h1   (tick_h1),
        .tick_h2   (tick_h2),
        .tick_end  (tick_end)
    );

    lc_cell_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_n),
        .lvl      (lvl),
        .locked   (locked),
        .tick_h1  (tick_h1),
        .tick_h2  (tick_h2),
        .tick_end (tick_end),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );

endmodule

// File: tb/tb_line_codec.sv
module tb_line_codec;
    localparam int OSR   = 16;
    localparam int NBITS = 65;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       tx_bit = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_line;
    logic       rx_line;
    logic       rx_bit;
    logic       rx_valid;

    always #10 clk = ~clk;   // 50 MHz

    assign rx_line = tx_line;

    line_codec #(.OSR(OSR)) dut (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .tx_bit   (tx_bit),
        .tx_en    (tx_en),
        .tx_line  (tx_line),
        .rx_line  (rx_line),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );

    int   n_run = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   rx_n = 0;
    int   last_cyc = 0;
    int   gap_bad = 0;
    bit   finished = 1'b0;
    logic rxq [0:255];
    logic sent [0:NBITS-1];

    always @(posedge clk) cyc <= cyc + 1;

    // Receive monitor: record each strobed bit and the spacing between strobes.
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (rx_n < 256) rxq[rx_n] = rx_bit;
            if (rx_n > 0 && (cyc - last_cyc) != OSR) gap_bad++;
            last_cyc = cyc;
            rx_n++;
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int exp, input bit at_least);
        n_run++;
        if (at_least ? (act < exp) : (act != exp)) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %s%0d", tag, what, act, at_least ? ">=" : "", exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            1, 2:    return "R2";
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            default: return "R1";
        endcase
    endfunction

    // Data pattern walking every 4-bit sequence, most significant bit first.
    function automatic logic pat_bit(input int k);
        return 1'((k / 4) >> (3 - (k % 4)));
    endfunction

    task automatic run_mode(input int m, input bit jitter);
        logic p, b, l1, l2;
        int   len;
        string tag;
        tag = mode_tag(m);
        rst = 1'b1;
        mode = 3'(m);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        rx_n = 0;
        gap_bad = 0;
        rst = 1'b0;
        @(negedge clk);
        check_bit("R7", "line after reset", tx_line, 1'b0);
        repeat (40) @(negedge clk);
        check_int("R8", "strobes before first edge", rx_n, 0, 1'b0);

        p = 1'b0;
        for (int i = 0; i < NBITS; i++) begin
            if (i == 0) b = (m == 2 || m == 6) ? 1'b0 : 1'b1;
            else        b = pat_bit(i - 1);
            sent[i] = b;
            case (m)
                1:       begin l1 = p ^ b;          l2 = l1;  end
                2:       begin l1 = p ^ ~b;         l2 = l1;  end
                3:       begin l1 = ~p;             l2 = b ? ~l1 : l1; end
                4:       begin l1 = ~p;             l2 = b ? l1 : ~l1; end
                5:       begin l1 = b;              l2 = ~b;  end
                6:       begin l1 = b ? p : ~p;     l2 = ~l1; end
                default: begin l1 = b;              l2 = b;   end
            endcase
            len = jitter ? ((i % 2) ? OSR + 1 : OSR - 1) : OSR;
            @(negedge clk);
            tx_en = 1'b1;
            tx_bit = b;
            @(negedge clk);
            tx_en = 1'b0;
            check_bit(tag, $sformatf("mode %0d cell %0d start level", m, i), tx_line, l1);
            repeat (OSR / 2 - 1) @(negedge clk);
            check_bit("R7", $sformatf("mode %0d cell %0d level just before mid", m, i), tx_line, l1);
            @(negedge clk);
            check_bit(tag, $sformatf("mode %0d cell %0d level after mid", m, i), tx_line, l2);
            repeat (len - OSR / 2 - 2) @(negedge clk);
            p = l2;
        end
        repeat (3 * OSR) @(negedge clk);

        check_int("R8", $sformatf("mode %0d strobe count", m), rx_n, NBITS, 1'b1);
        for (int i = 0; i < NBITS; i++) begin
            if (jitter)
                check_bit("R10", $sformatf("mode %0d jittered bit %0d", m, i), rxq[i], sent[i]);
            else
                check_bit("R9", $sformatf("mode %0d looped bit %0d", m, i), rxq[i], sent[i]);
        end
        if (!jitter)
            check_int("R8", $sformatf("mode %0d strobe spacing errors", m), gap_bad, 0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 8; m++) run_mode(m, 1'b0);
        run_mode(3, 1'b1);   // R10 biphase-mark with shifting boundaries
        run_mode(4, 1'b1);   // R10 biphase-space with shifting boundaries
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule